// File: doc/BRIEF.md
# Low-Power Core Clock and Power-State Controller

This block derives the CPU core clock enable and a set of binary-prescaled peripheral clock enables from one main oscillator clock. It also sequences the chip between three power states. In run, everything is clocked. In wait, the oscillator keeps going and the core is halted. In stop, the oscillator itself is switched off. Every output is a clock *enable* that is meant for clock-gating cells fed by the main clock, so the block itself runs entirely on that clock.

Software controls the block through two 8-bit control registers on a plain write port. The CPU signals a wait instruction with a one-cycle strobe. The interrupt controller supplies a request line, the enable of the requesting source and the global interrupt flag. The block latches the global flag while in run, so the flag that counts for waking is the one held at the moment a low-power state was entered.

On leaving stop, the block raises the oscillator enable and then keeps the core dark for a fixed settling count of main-clock cycles. The core then resumes at the reset ratio of eight, because entering stop forces that ratio. On leaving wait, the core resumes with whatever ratio it had when the strobe came.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset the block is in run, `osc_en` and `wdt_ce` are high, `adc_ce` is high, and the core enable pulses once every 8 cycles. Control register 0 resets to 8'h40 and control register 1 resets to 8'h00.
- R2: `reg_sel`=0 selects control register 0 and `reg_sel`=1 selects control register 1. If register 0 bit 6 is 1, the core ratio is 8. Otherwise register 1 bits [7:6] give the ratio: 00 is 1, 01 is 2, 10 is 4, 11 is 16. `core_ce` is high for one cycle out of every ratio cycles.
- R3: All enables come from one free-running 5-bit counter that starts at 0 after reset. A ratio held in the registers is adopted only on the cycle after the counter reaches 31. From then on, `core_ce` is high when the counter modulo the ratio equals ratio-1.
- R4: `per_ce[i]` is high when the counter modulo 2^i equals 2^i-1, for i = 0 to 5. `adc_ce` is high on every cycle in which the peripherals are clocked.
- R5: A `wait_strobe` pulse in run enters wait from the next cycle. In wait, `core_ce` and `wdt_ce` are low and `osc_en` stays high.
- R6: In wait, `per_ce` and `adc_ce` keep running if register 0 bit 5 is 0. If that bit is 1, they are all low.
- R7: A write to register 1 with bit 0 set, made in run, enters stop from the next cycle. This write takes priority over a `wait_strobe` in the same cycle. In stop, `osc_en` and every enable are low. The same write forces register 0 bit 6 to 1. Register 1 bit 0 always reads back as 0.
- R8: A low-power state is left only on a cycle where `irq_req`, `irq_src_en` and the global flag are all 1. The global flag is the value `gie` had on the last run cycle. Any other pending request leaves the state unchanged.
- R9: Release from wait returns to run on the next cycle, with the ratio that was in use before the strobe.
- R10: Release from stop raises `osc_en` on the next cycle. `core_ce`, `wdt_ce` and the peripheral enables stay low for WAKE_CYCLES cycles (default 256). After that, run resumes with the counter restarted at 0 and the core ratio at 8.
- R11: Register writes made in wait, in stop or during the stop wake-up delay have no effect.
- R12: Asserting `rst_n` low at any time returns the state, the counter and both registers to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select (0 = control 0, 1 = control 1) |
| reg_wdata | input | 8 | Register write data |
| wait_strobe | input | 1 | One-cycle pulse from a wait instruction |
| irq_req | input | 1 | Interrupt request pending |
| irq_src_en | input | 1 | Enable of the requesting interrupt source |
| gie | input | 1 | Global interrupt enable flag of the CPU |
| core_ce | output | 1 | Core clock enable |
| per_ce | output | NPER | Peripheral enables at ratios 1, 2, 4, 8, 16 and 32 |
| adc_ce | output | 1 | A-D converter clock enable |
| wdt_ce | output | 1 | Watchdog clock enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
The bench targets these corner cases:
- A ratio write made partway through a 32-cycle span. A design that switches at once would emit a shortened core period.
- A stop write and a wait strobe in the same cycle. A design with the wrong priority would leave the oscillator running.
- A pending interrupt that fails either the source-enable check or the latched global flag. A design with a weak wake check would leave stop or wait early.
- Register writes made while halted. A design that accepts them would come back from wait with a different ratio or peripheral gating.
- The stop exit. A design that skips the settling delay, or does not force the divide-by-8 ratio, would show core pulses too early or at the old rate.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_WAIT = 2'd1,
    PS_STOP = 2'd2,
    PS_WAKE = 2'd3
  } pstate_e;

  // Field positions inside the two control registers
  localparam int unsigned C0_DIV8_BIT  = 6;
  localparam int unsigned C0_PSTOP_BIT = 5;
  localparam int unsigned C1_STOP_BIT  = 0;
  localparam int unsigned C1_DHI_LSB   = 6;

  localparam logic [7:0] C0_RESET = 8'h40;
  localparam logic [7:0] C1_RESET = 8'h00;
  localparam logic [2:0] K_DIV8   = 3'd3;

  // log2 of the core ratio selected by the register fields
  function automatic logic [2:0] core_shift(input logic div8, input logic [1:0] dhi);
    logic [2:0] k;
    if (div8) begin
      k = K_DIV8;
    end else begin
      unique case (dhi)
        2'd0:    k = 3'd0;
        2'd1:    k = 3'd1;
        2'd2:    k = 3'd2;
        default: k = 3'd4;
      endcase
    end
    return k;
  endfunction

  // true when the low k bits of the count are all ones
  function automatic logic is_tick(input logic [7:0] cnt, input logic [2:0] k);
    logic [7:0] mask;
    mask = (8'd1 << k) - 8'd1;
    return (cnt & mask) == mask;
  endfunction

endpackage

// File: rtl/lpclk_divider.sv
module lpclk_divider
  import lpclk_pkg::*;
#(
  parameter int unsigned NPER = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic [2:0]      want_k,
  output logic [NPER-2:0] cnt_q,
  output logic [2:0]      act_k_q,
  output logic            wrap,
  output logic            core_tick,
  output logic [NPER-1:0] per_tick
);

  assign wrap      = &cnt_q;
  assign core_tick = is_tick(8'(cnt_q), act_k_q);

  for (genvar i = 0; i < NPER; i++) begin : g_per
    assign per_tick[i] = is_tick(8'(cnt_q), 3'(i));
  end

  // counter frozen at zero while the oscillator is off or settling;
  // ratio changes adopted only at the common boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_k_q <= K_DIV8;
    end else if (hold) begin
      cnt_q   <= '0;
      act_k_q <= want_k;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap) act_k_q <= want_k;
    end
  end

endmodule

// File: rtl/lpclk_pwr_fsm.sv
module lpclk_pwr_fsm
  import lpclk_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 256
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stop_req,
  input  logic    wait_req,
  input  logic    irq_req,
  input  logic    irq_src_en,
  input  logic    gie,
  output pstate_e state_q,
  output logic    wake_ok,
  output logic    stop_entry,
  output logic    wait_entry
);

  localparam int unsigned WW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [WW-1:0] WK_LAST = WW'(WAKE_CYCLES - 1);

  logic          gie_q;
  logic [WW-1:0] wk_q;
  pstate_e       state_d;

  assign wake_ok    = irq_req && irq_src_en && gie_q;
  assign stop_entry = (state_q == PS_RUN) && stop_req;
  assign wait_entry = (state_q == PS_RUN) && wait_req && !stop_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN: begin
        if (stop_entry)      state_d = PS_STOP;
        else if (wait_entry) state_d = PS_WAIT;
      end
      PS_WAIT: if (wake_ok)              state_d = PS_RUN;
      PS_STOP: if (wake_ok)              state_d = PS_WAKE;
      default: if (wk_q == WK_LAST)      state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      gie_q   <= 1'b0;
      wk_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == PS_RUN) gie_q <= gie;
      if (state_q == PS_WAKE && wk_q != WK_LAST) wk_q <= wk_q + 1'b1;
      else                                       wk_q <= '0;
    end
  end

endmodule

// File: rtl/lpclk_regs.sv
module lpclk_regs
  import lpclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       we,
  input  logic       sel,
  input  logic [7:0] wdata,
  input  logic       force_div8,
  output logic [7:0] ctl0_q,
  output logic [7:0] ctl1_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0_q <= C0_RESET;
      ctl1_q <= C1_RESET;
    end else begin
      if (accept && we) begin
        if (!sel) ctl0_q <= wdata;
        else      ctl1_q <= wdata & ~(8'd1 << C1_STOP_BIT);
      end
      if (force_div8) ctl0_q[C0_DIV8_BIT] <= 1'b1;
    end
  end

endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
  import lpclk_pkg::*;
#(
  parameter int unsigned NPER        = 6,
  parameter int unsigned WAKE_CYCLES = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [7:0]      reg_wdata,
  input  logic            wait_strobe,
  input  logic            irq_req,
  input  logic            irq_src_en,
  input  logic            gie,
  output logic            core_ce,
  output logic [NPER-1:0] per_ce,
  output logic            adc_ce,
  output logic            wdt_ce,
  output logic            osc_en
);

  pstate_e         state_q;
  logic            wake_ok, stop_entry, wait_entry;
  logic            stop_req, in_run, hold, per_run;
  logic [7:0]      ctl0_q, ctl1_q;
  logic [2:0]      want_k, act_k_q;
  logic [NPER-2:0] cnt_q;
  logic            wrap, core_tick;
  logic [NPER-1:0] per_tick;
  logic            unused_bits;

  assign stop_req = reg_we && reg_sel && reg_wdata[C1_STOP_BIT];
  assign in_run   = (state_q == PS_RUN);
  assign hold     = (state_q == PS_STOP) || (state_q == PS_WAKE);
  assign want_k   = core_shift(ctl0_q[C0_DIV8_BIT], ctl1_q[C1_DHI_LSB +: 2]);
  assign per_run  = in_run || ((state_q == PS_WAIT) && !ctl0_q[C0_PSTOP_BIT]);
  assign unused_bits = ^{ctl0_q[7], ctl0_q[4:0], ctl1_q[5:0], wrap};

  lpclk_pwr_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .wait_req   (wait_strobe),
    .irq_req    (irq_req),
    .irq_src_en (irq_src_en),
    .gie        (gie),
    .state_q    (state_q),
    .wake_ok    (wake_ok),
    .stop_entry (stop_entry),
    .wait_entry (wait_entry)
  );

  lpclk_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (in_run),
    .we         (reg_we),
    .sel        (reg_sel),
    .wdata      (reg_wdata),
    .force_div8 (stop_entry),
    .ctl0_q     (ctl0_q),
    .ctl1_q     (ctl1_q)
  );

  lpclk_divider #(.NPER(NPER)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .want_k    (want_k),
    .cnt_q     (cnt_q),
    .act_k_q   (act_k_q),
    .wrap      (wrap),
    .core_tick (core_tick),
    .per_tick  (per_tick)
  );

  assign core_ce = in_run && core_tick;
  assign per_ce  = per_run ? per_tick : '0;
  assign adc_ce  = per_run;
  assign wdt_ce  = in_run;
  assign osc_en  = (state_q != PS_STOP);

endmodule

// File: rtl/lpclk_ctrl_chk.sv
module lpclk_ctrl_chk
  import lpclk_pkg::*;
#(
  parameter int unsigned NPER = 6
) (
  input logic            clk,
  input logic            rst_n,
  input pstate_e         state_q,
  input logic            in_run,
  input logic            hold,
  input logic            stop_req,
  input logic            wait_strobe,
  input logic            wake_ok,
  input logic [NPER-2:0] cnt_q,
  input logic [2:0]      act_k_q,
  input logic [7:0]      ctl0_q,
  input logic [7:0]      ctl1_q,
  input logic            core_ce,
  input logic [NPER-1:0] per_ce,
  input logic            adc_ce,
  input logic            wdt_ce,
  input logic            osc_en
);

  p_stop_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && stop_req) |=> (!osc_en && !core_ce && per_ce == '0 && !adc_ce && ctl0_q[C0_DIV8_BIT]));

  p_wait_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && wait_strobe && !stop_req) |=> (!core_ce && !wdt_ce && osc_en));

  p_ratio_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_k_q) && !$past(hold)) |-> (cnt_q == '0));

  p_writes_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_run) |=> ($stable(ctl0_q) && $stable(ctl1_q)));

  p_no_false_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STOP && !wake_ok) |=> !osc_en);

  p_wake_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> (!core_ce && !wdt_ce && per_ce == '0));

  p_resume_div8_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (act_k_q == K_DIV8 && cnt_q == '0));

endmodule

bind lpclk_ctrl lpclk_ctrl_chk #(.NPER(NPER)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state_q     (state_q),
  .in_run      (in_run),
  .hold        (hold),
  .stop_req    (stop_req),
  .wait_strobe (wait_strobe),
  .wake_ok     (wake_ok),
  .cnt_q       (cnt_q),
  .act_k_q     (act_k_q),
  .ctl0_q      (ctl0_q),
  .ctl1_q      (ctl1_q),
  .core_ce     (core_ce),
  .per_ce      (per_ce),
  .adc_ce      (adc_ce),
  .wdt_ce      (wdt_ce),
  .osc_en      (osc_en)
);

// File: tb/lpclk_ctrl_tb.sv
module lpclk_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NPER       = 6;
  localparam int WAKE       = 256;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0]      reg_wdata = 8'h00;
  logic            wait_strobe = 1'b0, irq_req = 1'b0, irq_src_en = 1'b0, gie = 1'b0;
  logic            core_ce, adc_ce, wdt_ce, osc_en;
  logic [NPER-1:0] per_ce;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lpclk_ctrl #(.NPER(NPER), .WAKE_CYCLES(WAKE)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .wait_strobe(wait_strobe), .irq_req(irq_req), .irq_src_en(irq_src_en), .gie(gie),
    .core_ce(core_ce), .per_ce(per_ce), .adc_ce(adc_ce), .wdt_ce(wdt_ce), .osc_en(osc_en)
  );

  // ---------------- behavioural reference model ----------------
  // mode: 0 run, 1 wait, 2 stop, 3 settling after stop
  int         m_mode, m_phase, m_div, m_settle;
  logic [7:0] m_r0, m_r1;
  bit         m_gie;

  function automatic int ratio_of(input logic [7:0] r0, input logic [7:0] r1);
    if (r0[6]) return 8;
    case (r1[7:6])
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 16;
    endcase
  endfunction

  task automatic model_step();
    int nm, np, nd, ns; logic [7:0] n0, n1; bit ng, go_stop, go_wait, release_ok;
    if (!rst_n) begin
      m_mode = 0; m_phase = 0; m_div = 8; m_settle = 0;
      m_r0 = 8'h40; m_r1 = 8'h00; m_gie = 1'b0;
      return;
    end
    nm = m_mode; np = m_phase; nd = m_div; ns = m_settle;
    n0 = m_r0; n1 = m_r1; ng = m_gie;
    go_stop    = (m_mode == 0) && reg_we && reg_sel && reg_wdata[0];
    go_wait    = (m_mode == 0) && wait_strobe && !go_stop;
    release_ok = irq_req && irq_src_en && m_gie;
    if (m_mode == 0) begin
      ng = gie;
      if (reg_we) begin
        if (reg_sel) n1 = {reg_wdata[7:1], 1'b0};
        else         n0 = reg_wdata;
      end
      if (go_stop) n0[6] = 1'b1;
    end
    if (m_mode >= 2) begin
      np = 0; nd = ratio_of(m_r0, m_r1);
    end else begin
      np = (m_phase + 1) % 32;
      if (m_phase == 31) nd = ratio_of(m_r0, m_r1);
    end
    case (m_mode)
      0: if (go_stop) nm = 2; else if (go_wait) nm = 1;
      1: if (release_ok) nm = 0;
      2: if (release_ok) begin nm = 3; ns = 0; end
      default: if (m_settle == WAKE - 1) begin nm = 0; ns = 0; end
               else ns = m_settle + 1;
    endcase
    m_mode = nm; m_phase = np; m_div = nd; m_settle = ns;
    m_r0 = n0; m_r1 = n1; m_gie = ng;
  endtask

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  task automatic compare();
    bit pr; int pe;
    pr = (m_mode == 0) || (m_mode == 1 && !m_r0[5]);
    pe = 0;
    for (int i = 0; i < NPER; i++)
      if (pr && (m_phase % (1 << i)) == (1 << i) - 1) pe |= (1 << i);
    check("core_ce", int'(core_ce), int'((m_mode == 0) && (m_phase % m_div) == m_div - 1));
    check("per_ce",  int'(per_ce),  pe);
    check("adc_ce",  int'(adc_ce),  int'(pr));
    check("wdt_ce",  int'(wdt_ce),  int'(m_mode == 0));
    check("osc_en",  int'(osc_en),  int'(m_mode != 2));
  endtask

  always @(posedge clk) begin
    model_step();
    #1;
    if (rst_n && !done) compare();
  end

  // ---------------- stimulus ----------------
  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pulse_wait();
    @(negedge clk); wait_strobe = 1'b1;
    @(negedge clk); wait_strobe = 1'b0;
  endtask

  task automatic irq_pulse(input bit en);
    @(negedge clk); irq_req = 1'b1; irq_src_en = en;
    @(negedge clk); irq_req = 1'b0; irq_src_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    cycles(3);
    tag = "R1"; rst_n = 1'b1;
    cycles(40);
    // R2: each ratio encoding
    tag = "R2"; wr(1'b0, 8'h00); cycles(40);
    wr(1'b1, 8'h40); cycles(40);
    wr(1'b1, 8'h80); cycles(40);
    wr(1'b1, 8'hC0); cycles(70);
    // R3: change mid-span, adopted at wrap only
    tag = "R3"; cycles(5); wr(1'b1, 8'h40); cycles(45);
    tag = "R4"; wr(1'b1, 8'hC0); cycles(70);
    // R5 / R8 / R9: wait, rejected request, then release
    gie = 1'b1;
    tag = "R5"; pulse_wait(); cycles(20);
    tag = "R8"; irq_pulse(1'b0); cycles(10);
    tag = "R9"; irq_pulse(1'b1); cycles(40);
    // R6 / R11: peripheral gating in wait, writes ignored while halted
    tag = "R6"; wr(1'b0, 8'h20); pulse_wait(); cycles(20);
    tag = "R11"; wr(1'b1, 8'h00); wr(1'b0, 8'h00); cycles(5);
    irq_pulse(1'b1); cycles(70);
    // R7: stop write collides with wait strobe
    tag = "R7";
    @(negedge clk); reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h41; wait_strobe = 1'b1;
    @(negedge clk); reg_we = 1'b0; wait_strobe = 1'b0;
    cycles(20);
    tag = "R8"; irq_pulse(1'b0); cycles(10);
    tag = "R10"; irq_pulse(1'b1);
    tag = "R11"; wr(1'b0, 8'h00); wr(1'b1, 8'h80); cycles(10);
    tag = "R10"; cycles(WAKE + 40);
    // stop with the global flag latched low: request must not wake
    tag = "R8"; gie = 1'b0; cycles(2); wr(1'b1, 8'h01); gie = 1'b1;
    irq_pulse(1'b1); cycles(20);
    // R12: reset from stop, then from run with altered registers
    tag = "R12"; @(negedge clk); rst_n = 1'b0; cycles(2); rst_n = 1'b1; cycles(40);
    wr(1'b0, 8'h20); wr(1'b1, 8'h80); cycles(7);
    @(negedge clk); rst_n = 1'b0; cycles(2); rst_n = 1'b1; cycles(40);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

endmodule